// File: doc/BRIEF.md
# Priority Peripheral-to-Pin Crossbar

This block routes up to thirty on-chip peripheral signals onto thirty-two general-purpose pins, which are grouped as four 8-bit ports. Each signal that is switched on receives the lowest-numbered pin that is still free. Signals are handed out in a fixed ranking, so enabling a peripheral that ranks higher moves every peripheral that ranks below it.

An external memory interface can claim the low ports. When it does, its strobe pins are taken out of the pool. During the execution phase of an off-chip access, it also takes over every pin it uses, whatever the crossbar assignment. Pins that receive no signal fall back to the port data value and its output enable.

The pin assignment is computed combinationally. A registered copy of the owner map and a per-signal "could not be placed" flag are exported for the rest of the chip.

Top module: `xbar_top`

## Requirements
- R1: Signals are ranked by index 0..29, in this order: TX0 (0), RX0 (1), SCK (2), MISO (3), MOSI (4), NSS (5), SDA (6), SCL (7), TX1 (8), RX1 (9), CEX0..CEX5 (10..15), then `en_single` bits 0..13 (16..29). Pins are numbered 0..31, where pin = 8*port + bit. Each requested signal, taken in rank order, owns the lowest free pin not yet taken.
- R2: `en_uart0` requests signals 0 and 1. `en_spi` requests signals 2 to 5. `en_smb` requests signals 6 and 7. `en_uart1` requests signals 8 and 9. Bit j of `en_single` requests signal 16+j.
- R3: `pca_cnt` requests the first N capture/compare outputs starting at signal 10. Any value above 6 is treated as 6.
- R4: When `spi_3wire` is 1, signal 5 is not requested, and the signals below it in the ranking move up by one pin.
- R5: When `emif_low` is 1, pins 7 and 6 are never assigned. When `emif_mux` is also 1, pin 5 is never assigned either.
- R6: A requested signal that finds no free pin is dropped, and its bit in `unplaced` is 1.
- R7: `owner_map` holds 5 bits per pin: field p is bits [5p+4:5p]. Each field holds the owning signal index, or 31 if the pin has no owner. `owner_map` and `unplaced` are registered. They follow an input change at the next rising clock edge. On reset, every field reads 31 and `unplaced` reads 0.
- R8: An owned pin drives `sig_out` and `sig_oe` of its owner. A pin with no owner drives `port_dout[p]` and `port_oe[p]`. Both paths are combinational.
- R9: When `emif_busy` and `emif_low` are both 1, the memory interface takes over a set of pins. These are pins 5 to 7 (pin 5 only in multiplexed mode), pins 8 to 15 (only in non-multiplexed mode) and pins 16 to 31. On these pins, `pin_out` equals `emif_dout` and `pin_oe` is 1. The exception is pins 24 to 31 when `emif_rd` is 1: there `pin_oe` is 0. When `emif_low` is 0, `emif_busy` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_uart0 | input | 1 | First UART group enable |
| en_spi | input | 1 | SPI group enable |
| en_smb | input | 1 | Two-wire bus group enable |
| en_uart1 | input | 1 | Second UART group enable |
| pca_cnt | input | 3 | Number of capture/compare outputs requested |
| en_single | input | 14 | Enables for the single signals ranked 16..29 |
| spi_3wire | input | 1 | SPI in 3-wire mode; the select signal is not routed |
| emif_low | input | 1 | Memory interface placed on the low ports |
| emif_mux | input | 1 | Memory interface in multiplexed address/data mode |
| emif_busy | input | 1 | Execution phase of an off-chip access |
| emif_rd | input | 1 | The current access is a read |
| emif_dout | input | 32 | Per-pin values driven by the memory interface |
| sig_out | input | 30 | Per-signal output values |
| sig_oe | input | 30 | Per-signal output enables |
| port_dout | input | 32 | Port data values for pins with no owner |
| port_oe | input | 32 | Port output enables for pins with no owner |
| pin_out | output | 32 | Pin drive values |
| pin_oe | output | 32 | Pin output enables |
| owner_map | output | 160 | Registered owner index for each pin |
| unplaced | output | 30 | Registered flags for requested signals that were dropped |

## Verification
Two functions can act in the same cycle: a memory access that overrides pins, and a crossbar assignment whose owners also sit on those pins. This happens because the ports above P0 are assigned to peripherals and taken over by the interface at the same time. The bench provokes this by enabling every peripheral and asserting `emif_busy`, first for a write and then for a read. It then checks that the overridden pins show the interface values, with drivers turned off on the data bus during the read. At the same time, it checks that the owner map still reports the peripheral owners and that pins outside the interface keep their peripheral drive.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  parameter int NSIG    = 30;
  parameter int PORTW   = 8;
  parameter int NPORT   = 4;
  parameter int NPIN    = NPORT * PORTW;
  parameter int OW      = 5;
  parameter int NSINGLE = 14;
  parameter int NPCA    = 6;
  parameter int CW      = $clog2(NPIN + 1);
  parameter logic [OW-1:0] NONE = '1;

  // ranking anchors
  parameter int SIG_SEL   = 5;
  parameter int SIG_PCA0  = 10;
  parameter int SIG_SGL0  = 16;

  // pins owned by the memory interface
  parameter int WR_PIN  = 7;
  parameter int RD_PIN  = 6;
  parameter int ALE_PIN = 5;
  parameter int P1_LO   = 8;
  parameter int P2_LO   = 16;
  parameter int P3_LO   = 24;

  function automatic logic ctrl_rsv(input int p, input logic low, input logic mux);
    return low && ((p == WR_PIN) || (p == RD_PIN) || (mux && p == ALE_PIN));
  endfunction
endpackage

// File: rtl/xbar_req.sv
module xbar_req
  import xbar_pkg::*;
(
  input  logic               en_uart0,
  input  logic               en_spi,
  input  logic               en_smb,
  input  logic               en_uart1,
  input  logic [2:0]         pca_cnt,
  input  logic [NSINGLE-1:0] en_single,
  input  logic               spi_3wire,
  output logic [NSIG-1:0]    req
);
  logic [2:0] pca_eff;
  assign pca_eff = (pca_cnt > 3'(NPCA)) ? 3'(NPCA) : pca_cnt;

  assign req[1:0] = {2{en_uart0}};
  assign req[4:2] = {3{en_spi}};
  assign req[SIG_SEL] = en_spi && !spi_3wire;
  assign req[7:6] = {2{en_smb}};
  assign req[9:8] = {2{en_uart1}};

  for (genvar k = 0; k < NPCA; k++) begin : g_pca
    assign req[SIG_PCA0 + k] = (3'(k) < pca_eff);
  end

  for (genvar j = 0; j < NSINGLE; j++) begin : g_sgl
    assign req[SIG_SGL0 + j] = en_single[j];
  end
endmodule

// File: rtl/xbar_alloc.sv
module xbar_alloc
  import xbar_pkg::*;
(
  input  logic [NSIG-1:0]    req,
  input  logic               emif_low,
  input  logic               emif_mux,
  output logic [NPIN*OW-1:0] own_flat,
  output logic [NSIG-1:0]    unpl
);
  logic [CW-1:0] srank [NSIG];
  logic [CW-1:0] frank [NPIN];
  logic [NPIN-1:0] rsv;
  logic [CW-1:0] nfree;

  always_comb begin
    logic [CW-1:0] acc;
    acc = '0;
    for (int i = 0; i < NSIG; i++) begin
      srank[i] = acc;
      acc = acc + CW'(req[i]);
    end
  end

  always_comb begin
    logic [CW-1:0] facc;
    facc = '0;
    for (int p = 0; p < NPIN; p++) begin
      rsv[p]   = ctrl_rsv(p, emif_low, emif_mux);
      frank[p] = facc;
      facc = facc + CW'(!rsv[p]);
    end
    nfree = facc;
  end

  always_comb begin
    for (int p = 0; p < NPIN; p++) begin
      own_flat[p*OW +: OW] = NONE;
      for (int i = 0; i < NSIG; i++) begin
        if (req[i] && !rsv[p] && srank[i] == frank[p]) own_flat[p*OW +: OW] = OW'(i);
      end
    end
    for (int i = 0; i < NSIG; i++) unpl[i] = req[i] && (srank[i] >= nfree);
  end
endmodule

// File: rtl/xbar_pinmux.sv
module xbar_pinmux
  import xbar_pkg::*;
(
  input  logic [NPIN*OW-1:0] own_flat,
  input  logic [NSIG-1:0]    sig_out,
  input  logic [NSIG-1:0]    sig_oe,
  input  logic [NPIN-1:0]    port_dout,
  input  logic [NPIN-1:0]    port_oe,
  input  logic               emif_low,
  input  logic               emif_mux,
  input  logic               emif_busy,
  input  logic               emif_rd,
  input  logic [NPIN-1:0]    emif_dout,
  output logic [NPIN-1:0]    pin_out,
  output logic [NPIN-1:0]    pin_oe
);
  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic [OW-1:0] o;
    logic emif_pin, dbus;
    assign o = own_flat[p*OW +: OW];
    assign dbus = (p >= P3_LO);
    assign emif_pin = ctrl_rsv(p, 1'b1, emif_mux) || (p >= P2_LO) ||
                      (!emif_mux && p >= P1_LO);
    always_comb begin
      if (emif_busy && emif_low && emif_pin) begin
        pin_out[p] = emif_dout[p];
        pin_oe[p]  = !(dbus && emif_rd);
      end else if (o != NONE && int'(o) < NSIG) begin
        pin_out[p] = sig_out[o];
        pin_oe[p]  = sig_oe[o];
      end else begin
        pin_out[p] = port_dout[p];
        pin_oe[p]  = port_oe[p];
      end
    end
  end
endmodule

// File: rtl/xbar_top.sv
module xbar_top
  import xbar_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_uart0,
  input  logic               en_spi,
  input  logic               en_smb,
  input  logic               en_uart1,
  input  logic [2:0]         pca_cnt,
  input  logic [NSINGLE-1:0] en_single,
  input  logic               spi_3wire,
  input  logic               emif_low,
  input  logic               emif_mux,
  input  logic               emif_busy,
  input  logic               emif_rd,
  input  logic [NPIN-1:0]    emif_dout,
  input  logic [NSIG-1:0]    sig_out,
  input  logic [NSIG-1:0]    sig_oe,
  input  logic [NPIN-1:0]    port_dout,
  input  logic [NPIN-1:0]    port_oe,
  output logic [NPIN-1:0]    pin_out,
  output logic [NPIN-1:0]    pin_oe,
  output logic [NPIN*OW-1:0] owner_map,
  output logic [NSIG-1:0]    unplaced
);
  logic [NSIG-1:0]    req;
  logic [NPIN*OW-1:0] own_c, own_d;
  logic [NSIG-1:0]    unpl_c, unpl_d;
  logic               upd_en;

  xbar_req u_req (
    .en_uart0(en_uart0), .en_spi(en_spi), .en_smb(en_smb), .en_uart1(en_uart1),
    .pca_cnt(pca_cnt), .en_single(en_single), .spi_3wire(spi_3wire), .req(req)
  );

  xbar_alloc u_alloc (
    .req(req), .emif_low(emif_low), .emif_mux(emif_mux),
    .own_flat(own_c), .unpl(unpl_c)
  );

  xbar_pinmux u_mux (
    .own_flat(own_c), .sig_out(sig_out), .sig_oe(sig_oe),
    .port_dout(port_dout), .port_oe(port_oe),
    .emif_low(emif_low), .emif_mux(emif_mux), .emif_busy(emif_busy),
    .emif_rd(emif_rd), .emif_dout(emif_dout),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // next state
  always_comb begin
    upd_en = (own_c != owner_map) || (unpl_c != unplaced);
    own_d  = upd_en ? own_c  : owner_map;
    unpl_d = upd_en ? unpl_c : unplaced;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_map <= '1;
      unplaced  <= '0;
    end else if (upd_en) begin
      owner_map <= own_d;
      unplaced  <= unpl_d;
    end
  end
endmodule

// File: rtl/xbar_chk.sv
module xbar_chk
  import xbar_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               spi_3wire,
  input logic               emif_low,
  input logic               emif_mux,
  input logic               emif_busy,
  input logic               emif_rd,
  input logic [NPIN*OW-1:0] own_c,
  input logic [NSIG-1:0]    unpl_c,
  input logic [NPIN*OW-1:0] owner_map,
  input logic [NPIN-1:0]    pin_oe
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_owner_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> owner_map == $past(own_c));

  assert_strobe_pins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    emif_low |-> (own_c[WR_PIN*OW +: OW] == NONE) && (own_c[RD_PIN*OW +: OW] == NONE));

  assert_ale_pin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (emif_low && emif_mux) |-> own_c[ALE_PIN*OW +: OW] == NONE);

  assert_read_drivers_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (emif_low && emif_busy && emif_rd) |-> pin_oe[NPIN-1:P3_LO] == '0);

  assert_full_before_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|unpl_c) |-> own_c[(NPIN-1)*OW +: OW] != NONE);

  for (genvar p = 0; p < NPIN; p++) begin : g_sel
    assert_no_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
      spi_3wire |-> own_c[p*OW +: OW] != OW'(SIG_SEL));
  end
endmodule

bind xbar_top xbar_chk u_chk (
  .clk(clk), .rst_n(rst_n), .spi_3wire(spi_3wire), .emif_low(emif_low),
  .emif_mux(emif_mux), .emif_busy(emif_busy), .emif_rd(emif_rd),
  .own_c(own_c), .unpl_c(unpl_c), .owner_map(owner_map), .pin_oe(pin_oe)
);

// File: tb/tb_xbar_top.sv
`timescale 1ns/1ps
module tb_xbar_top;
  localparam int NS = 30, NP = 32, W = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, en_uart0, en_spi, en_smb, en_uart1, spi_3wire, emif_low, emif_mux, emif_busy, emif_rd;
  logic [2:0] pca_cnt;
  logic [13:0] en_single;
  logic [NP-1:0] emif_dout, port_dout, port_oe, pin_out, pin_oe;
  logic [NS-1:0] sig_out, sig_oe, unplaced;
  logic [NP*W-1:0] owner_map;

  xbar_top dut (.*);

  typedef struct {
    logic [NP*W-1:0] own;
    logic [NS-1:0]   unp;
    logic [NP-1:0]   po, poe;
    string           tag;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0;
  logic [NP*W-1:0] last_own = '1;
  bit done = 0;

  task automatic chk(input string tag, input logic [NP*W-1:0] act, input logic [NP*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input string tag, input logic u0, input logic spi, input logic smb,
                       input logic u1, input logic [2:0] pca, input logic [13:0] sgl,
                       input logic w3, input logic el, input logic em, input logic bz,
                       input logic rd);
    item_t it;
    logic [NS-1:0] rq;
    logic [NP-1:0] rs;
    int p, n;
    @(negedge clk);
    en_uart0 = u0; en_spi = spi; en_smb = smb; en_uart1 = u1; pca_cnt = pca;
    en_single = sgl; spi_3wire = w3; emif_low = el; emif_mux = em;
    emif_busy = bz; emif_rd = rd;
    #1;
    chk({tag, " R7 map holds until edge"}, owner_map, last_own);
    // expected request list from the ranking rules
    rq = '0;
    rq[0] = u0; rq[1] = u0;
    rq[2] = spi; rq[3] = spi; rq[4] = spi; rq[5] = spi && !w3;
    rq[6] = smb; rq[7] = smb; rq[8] = u1; rq[9] = u1;
    n = (pca > 6) ? 6 : int'(pca);
    for (int k = 0; k < n; k++) rq[10+k] = 1'b1;
    for (int j = 0; j < 14; j++) rq[16+j] = sgl[j];
    rs = '0;
    if (el) begin rs[7] = 1'b1; rs[6] = 1'b1; if (em) rs[5] = 1'b1; end
    it.own = '1; it.unp = '0; it.tag = tag;
    p = 0;
    for (int i = 0; i < NS; i++) begin
      if (rq[i]) begin
        while (p < NP && rs[p]) p++;
        if (p < NP) begin it.own[p*W +: W] = W'(i); p++; end
        else it.unp[i] = 1'b1;
      end
    end
    for (int k = 0; k < NP; k++) begin
      int o;
      logic ep;
      o  = int'(it.own[k*W +: W]);
      ep = (k == 7) || (k == 6) || (em && k == 5) || (k >= 16) || (!em && k >= 8);
      if (bz && el && ep) begin
        it.po[k] = emif_dout[k]; it.poe[k] = !(rd && k >= 24);
      end else if (o != 31) begin
        it.po[k] = sig_out[o]; it.poe[k] = sig_oe[o];
      end else begin
        it.po[k] = port_dout[k]; it.poe[k] = port_oe[k];
      end
    end
    last_own = it.own;
    q.push_back(it);
  endtask

  // monitor: compare after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        item_t e;
        e = q.pop_front();
        chk({e.tag, " owner_map"}, owner_map, e.own);
        chk({e.tag, " unplaced"}, {130'b0, unplaced}, {130'b0, e.unp});
        chk({e.tag, " pin_out"}, {128'b0, pin_out}, {128'b0, e.po});
        chk({e.tag, " pin_oe"}, {128'b0, pin_oe}, {128'b0, e.poe});
      end
    end
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    {en_uart0, en_spi, en_smb, en_uart1, spi_3wire, emif_low, emif_mux, emif_busy, emif_rd} = '0;
    pca_cnt = '0; en_single = '0;
    sig_out = 30'h2B5_96C3; sig_oe = 30'h3F0F_33CC;
    port_dout = 32'hA5C3_0F96; port_oe = 32'h3C5A_F00F; emif_dout = 32'h6E1D_B247;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 reset owner map", owner_map, '1);
    chk("R7 reset unplaced", {130'b0, unplaced}, '0);

    drive("R1 R2 R8 first UART only", 1,0,0,0, 0, 14'h0, 0,0,0,0,0);
    drive("R2 four groups", 1,1,1,1, 0, 14'h0, 0,0,0,0,0);
    drive("R4 three-wire SPI", 1,1,1,1, 0, 14'h0, 1,0,0,0,0);
    drive("R3 three PCA outputs", 0,0,0,1, 3'd3, 14'h0, 0,0,0,0,0);
    drive("R3 PCA count clamp", 0,0,0,0, 3'd7, 14'h1, 0,0,0,0,0);
    drive("R1 R8 singles pattern", 0,0,1,0, 3'd1, 14'h2A55, 0,0,0,0,0);
    drive("R5 interface non-mux", 1,1,1,0, 0, 14'h0, 0,1,0,0,0);
    drive("R5 interface mux", 1,1,1,0, 0, 14'h0, 0,1,1,0,0);
    drive("R6 all enabled mux drops last", 1,1,1,1, 3'd6, 14'h3FFF, 0,1,1,0,0);
    drive("R6 all enabled non-mux fits", 1,1,1,1, 3'd6, 14'h3FFF, 0,1,0,0,0);
    drive("R9 write override with owners", 1,1,1,1, 3'd6, 14'h3FFF, 0,1,1,1,0);
    drive("R9 read drivers off", 1,1,1,1, 3'd6, 14'h3FFF, 0,1,1,1,1);
    drive("R9 non-mux read", 1,1,0,0, 3'd2, 14'h00F0, 0,1,0,1,1);
    drive("R9 busy ignored off low ports", 1,1,1,1, 3'd6, 14'h3FFF, 0,0,1,1,1);
    drive("R1 R7 back to idle", 0,0,0,0, 0, 14'h0, 0,0,0,0,0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule